// File: doc/BRIEF.md
# Spiking Neuron Bank with Leak, Threshold and Floor

This block keeps a bank of integrate-and-fire neurons, each with its own signed membrane potential. When a tick strobe arrives, every neuron adds the weighted synaptic sum for that tick and its own signed leak to its potential. It then compares the new value with a shared threshold and sets its spike bit if the value has reached the threshold. After that it applies the selected reset action and, when enabled, lifts the result up to a lower bound. The potentials are kept in registers between ticks. They saturate at the signed limits of their width and never wrap.

All neurons are updated in parallel in the same cycle, so any tick rate up to one tick per clock works. With threshold 1, reset-to-zero and a floor of 0 enabled, the unit acts as a memoryless binary step. Each tick's spike then depends only on that tick's sum and leak, and a fresh input frame can be presented on every tick.

Top module: `lif_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every potential becomes 0 and every spike bit becomes 0.
- R2: On a clock edge with `tick_i` high, neuron k's new value is its potential plus its sum lane plus its leak lane. Lane k of each packed bus occupies bits [k*W +: W], and all values are two's complement. The leak lies in -255..+255. Each neuron uses only its own lanes.
- R3: The spike bit of a neuron is 1 exactly when its new value is greater than or equal to the signed threshold. It is registered, so it is visible in the cycle after the tick, and it holds its value until the next tick.
- R4: On clock edges with `tick_i` low, potentials and spike bits do not change, whatever the sum and leak inputs do.
- R5: The reset action is selected by `rmode_i`, and it applies only to neurons that spiked. Encoding 00 sets the potential to 0. Encoding 01 keeps the new value. Encoding 10 subtracts the threshold (saturating). Encoding 11 behaves like 00. A neuron that did not spike keeps its new value.
- R6: When `floor_en_i` is 1 and the value left after the reset step is below `floor_i`, the potential becomes `floor_i`. The threshold compare uses the value before this floor step.
- R7: The new value and the subtracted value saturate at the most positive and most negative values of the potential width instead of wrapping.
- R8: With threshold 1, mode 00, floor 0 and floor enabled, every potential is 0 after each tick, and the spike equals (sum + leak >= 1) for that tick alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Update strobe, one neuron update per high cycle |
| sum_i | input | N*SUM_W | Per-neuron signed synaptic sum lanes |
| leak_i | input | N*LEAK_W | Per-neuron signed leak lanes |
| thresh_i | input | POT_W | Signed firing threshold shared by all neurons |
| rmode_i | input | 2 | Reset action after a spike |
| floor_i | input | POT_W | Signed lower bound |
| floor_en_i | input | 1 | Enables the lower-bound snap |
| spike_o | output | N | Registered spike bits |
| pot_o | output | N*POT_W | Registered signed potentials |

## Verification
The assertions take for granted that no leak lane ever carries -256, the one 9-bit code outside the allowed range. They also assume that the threshold, floor and mode inputs are settled before the cycle in which the tick is sampled. The bench changes inputs only on falling clock edges and uses leak values within -255..+255. It also keeps the floor inside the potential range, so the floor check (potential not below the previous floor after a tick) is meaningful. The configuration is changed only between ticks, never in the same cycle as a strobe.

// File: rtl/lif_pkg.sv
package lif_pkg;
  typedef enum logic [1:0] {
    RM_ZERO     = 2'b00,
    RM_KEEP     = 2'b01,
    RM_SUBTRACT = 2'b10,
    RM_ZERO_ALT = 2'b11
  } reset_mode_e;
endpackage

// File: rtl/lif_sat.sv
module lif_sat #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  x_i,
  output logic signed [OUT_W-1:0] y_o
);
  localparam int PAD_W = IN_W - OUT_W + 1;
  localparam logic signed [IN_W-1:0] MAXV = {{PAD_W{1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] MINV = {{PAD_W{1'b1}}, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (x_i > MAXV)      y_o = MAXV[OUT_W-1:0];
    else if (x_i < MINV) y_o = MINV[OUT_W-1:0];
    else                 y_o = x_i[OUT_W-1:0];
  end
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
  import lif_pkg::*;
#(
  parameter int POT_W  = 16,
  parameter int SUM_W  = 12,
  parameter int LEAK_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_i,
  input  logic [SUM_W-1:0]        sum_i,
  input  logic [LEAK_W-1:0]       leak_i,
  input  logic signed [POT_W-1:0] thresh_i,
  input  logic [1:0]              rmode_i,
  input  logic signed [POT_W-1:0] floor_i,
  input  logic                    floor_en_i,
  output logic                    spike_o,
  output logic signed [POT_W-1:0] pot_o
);
  localparam int EXT_W = POT_W + 2;

  logic signed [POT_W-1:0] pot_q;
  logic                    spike_q;
  logic signed [EXT_W-1:0] raw_sum, raw_sub;
  logic signed [POT_W-1:0] v_new, v_sub, v_rst, v_next;
  logic                    fire;
  reset_mode_e             mode;

  assign mode = reset_mode_e'(rmode_i);

  // integrate: potential + synaptic sum + leak, in a widened domain
  assign raw_sum = {{(EXT_W-POT_W){pot_q[POT_W-1]}}, pot_q}
                 + {{(EXT_W-SUM_W){sum_i[SUM_W-1]}}, sum_i}
                 + {{(EXT_W-LEAK_W){leak_i[LEAK_W-1]}}, leak_i};

  lif_sat #(.IN_W(EXT_W), .OUT_W(POT_W)) u_sat_sum (.x_i(raw_sum), .y_o(v_new));

  assign fire = (v_new >= thresh_i);

  assign raw_sub = {{(EXT_W-POT_W){v_new[POT_W-1]}}, v_new}
                 - {{(EXT_W-POT_W){thresh_i[POT_W-1]}}, thresh_i};

  lif_sat #(.IN_W(EXT_W), .OUT_W(POT_W)) u_sat_sub (.x_i(raw_sub), .y_o(v_sub));

  always_comb begin
    v_rst = v_new;
    if (fire) begin
      unique case (mode)
        RM_KEEP:     v_rst = v_new;
        RM_SUBTRACT: v_rst = v_sub;
        default:     v_rst = '0;
      endcase
    end
    v_next = (floor_en_i && (v_rst < floor_i)) ? floor_i : v_rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pot_q   <= '0;
      spike_q <= 1'b0;
    end else if (tick_i) begin
      pot_q   <= v_next;
      spike_q <= fire;
    end
  end

  assign pot_o   = pot_q;
  assign spike_o = spike_q;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pot_q == '0 && !spike_q));

  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> ($stable(pot_q) && $stable(spike_q)));

  assert_spike_needs_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(spike_q) |-> $past(tick_i));

  assert_zero_reset_R5: assert property (@(posedge clk) disable iff (rst)
    (tick_i && mode == RM_ZERO && !floor_en_i) |=> (!spike_q || pot_q == '0));

  assert_floor_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (tick_i && floor_en_i) |=> (pot_q >= $past(floor_i)));
endmodule

// File: rtl/lif_bank.sv
module lif_bank #(
  parameter int N      = 4,
  parameter int POT_W  = 16,
  parameter int SUM_W  = 12,
  parameter int LEAK_W = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_i,
  input  logic [N*SUM_W-1:0]    sum_i,
  input  logic [N*LEAK_W-1:0]   leak_i,
  input  logic [POT_W-1:0]      thresh_i,
  input  logic [1:0]            rmode_i,
  input  logic [POT_W-1:0]      floor_i,
  input  logic                  floor_en_i,
  output logic [N-1:0]          spike_o,
  output logic [N*POT_W-1:0]    pot_o
);
  localparam logic [LEAK_W-1:0] LEAK_BAD = {1'b1, {(LEAK_W-1){1'b0}}};

  for (genvar k = 0; k < N; k++) begin : g_lane
    logic signed [POT_W-1:0] pot_k;

    lif_neuron #(.POT_W(POT_W), .SUM_W(SUM_W), .LEAK_W(LEAK_W)) u_neuron (
      .clk        (clk),
      .rst        (rst),
      .tick_i     (tick_i),
      .sum_i      (sum_i[k*SUM_W +: SUM_W]),
      .leak_i     (leak_i[k*LEAK_W +: LEAK_W]),
      .thresh_i   (thresh_i),
      .rmode_i    (rmode_i),
      .floor_i    (floor_i),
      .floor_en_i (floor_en_i),
      .spike_o    (spike_o[k]),
      .pot_o      (pot_k)
    );

    assign pot_o[k*POT_W +: POT_W] = pot_k;

    assert_leak_range_R2: assert property (@(posedge clk) disable iff (rst)
      leak_i[k*LEAK_W +: LEAK_W] != LEAK_BAD);
  end
endmodule

// File: tb/lif_bank_tb.sv
module lif_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, POT_W = 16, SUM_W = 12, LEAK_W = 9;

  typedef struct packed {
    logic signed [11:0] s3, s2, s1, s0;
    logic signed [8:0]  l3, l2, l1, l0;
    logic [3:0]         exp_spk;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{12'sd0,    12'sd0,    12'sd0,     12'sd0,  9'sd0,   9'sd0,    9'sd0,    9'sd0,   4'b0000},
    '{12'sd1,    12'sd0,   -12'sd1,     12'sd5,  9'sd0,   9'sd1,    9'sd1,   -9'sd5,   4'b1100},
    '{-12'sd100, 12'sd2047,-12'sd2048,  12'sd3,  9'sd100,-9'sd255,  9'sd255, -9'sd2,   4'b0101},
    '{12'sd0,   -12'sd256,  12'sd256,  -12'sd1,  9'sd255, 9'sd255, -9'sd255,  9'sd0,   4'b1010},
    '{12'sd10,   12'sd10,   12'sd10,    12'sd10,-9'sd9,  -9'sd9,   -9'sd9,   -9'sd9,   4'b1111},
    '{-12'sd1,  -12'sd1,   -12'sd1,    -12'sd1,  9'sd0,   9'sd0,    9'sd0,    9'sd0,   4'b0000}
  };

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, floor_en = 1'b0;
  logic [N*SUM_W-1:0]  sum_v  = '0;
  logic [N*LEAK_W-1:0] leak_v = '0;
  logic [POT_W-1:0]    thr = '0, flr = '0;
  logic [1:0]          rmode = 2'b00;
  logic [N-1:0]        spk;
  logic [N*POT_W-1:0]  pot;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lif_bank #(.N(N), .POT_W(POT_W), .SUM_W(SUM_W), .LEAK_W(LEAK_W)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .sum_i(sum_v), .leak_i(leak_v),
    .thresh_i(thr), .rmode_i(rmode), .floor_i(flr), .floor_en_i(floor_en),
    .spike_o(spk), .pot_o(pot));

  function automatic int potk(int k);
    return int'($signed(pot[k*POT_W +: POT_W]));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic set_lane0(int s, int l);
    sum_v  = '0;
    leak_v = '0;
    sum_v[0 +: SUM_W]   = SUM_W'(s);
    leak_v[0 +: LEAK_W] = LEAK_W'(l);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(spk == '0, "R1 spikes", int'(spk), 0);
    chk(pot == '0, "R1 potentials", potk(0), 0);

    // R8 / R2 / R3: binary step configuration, table walk
    thr = 16'd1; rmode = 2'b00; flr = '0; floor_en = 1'b1;
    foreach (VEC[i]) begin
      sum_v  = {VEC[i].s3, VEC[i].s2, VEC[i].s1, VEC[i].s0};
      leak_v = {VEC[i].l3, VEC[i].l2, VEC[i].l1, VEC[i].l0};
      do_tick();
      chk(spk == VEC[i].exp_spk, "R8 spike vector", int'(spk), int'(VEC[i].exp_spk));
      chk(pot == '0, "R8 potentials zero", potk(0), 0);
    end

    // R2: accumulation with keep mode
    do_reset();
    thr = 16'd100; rmode = 2'b01; floor_en = 1'b0;
    set_lane0(30, 5);
    do_tick();
    chk(potk(0) == 35, "R2 first add", potk(0), 35);
    chk(spk == 4'b0000, "R3 below threshold", int'(spk), 0);
    do_tick();
    chk(potk(0) == 70, "R2 second add", potk(0), 70);
    chk(potk(1) == 0, "R2 lane independence", potk(1), 0);
    do_tick();
    chk(potk(0) == 105, "R5 keep after spike", potk(0), 105);
    chk(spk == 4'b0001, "R3 spike at threshold crossing", int'(spk), 1);

    // R4: no tick, inputs change
    set_lane0(-500, -200);
    repeat (3) @(negedge clk);
    chk(potk(0) == 105, "R4 potential held", potk(0), 105);
    chk(spk == 4'b0001, "R4 spike held", int'(spk), 1);

    // R5: zero mode
    rmode = 2'b00; set_lane0(0, 0);
    do_tick();
    chk(spk == 4'b0001, "R5 zero-mode spike", int'(spk), 1);
    chk(potk(0) == 0, "R5 zero-mode reset", potk(0), 0);

    // R5: subtract mode then alternate zero encoding
    rmode = 2'b10; set_lane0(150, 0);
    do_tick();
    chk(potk(0) == 50, "R5 subtract threshold", potk(0), 50);
    rmode = 2'b11; set_lane0(60, 0);
    do_tick();
    chk(spk == 4'b0001 && potk(0) == 0, "R5 code 11 acts as zero", potk(0), 0);

    // R6: floor snap and disable
    rmode = 2'b01; flr = -16'sd20; floor_en = 1'b1; set_lane0(-50, 0);
    do_tick();
    chk(potk(0) == -20, "R6 snap to floor", potk(0), -20);
    floor_en = 1'b0;
    do_tick();
    chk(potk(0) == -70, "R6 floor disabled", potk(0), -70);

    // R6: compare precedes floor
    rmode = 2'b00; thr = 16'd5; flr = 16'd10; floor_en = 1'b1; set_lane0(80, 0);
    do_tick();
    chk(spk == 4'b0001, "R6 spike on pre-floor value", int'(spk), 1);
    chk(potk(0) == 10, "R6 reset value lifted to floor", potk(0), 10);

    // R7: positive saturation
    rmode = 2'b01; thr = 16'sd32767; floor_en = 1'b0; set_lane0(2047, 255);
    for (int i = 0; i < 15; i++) do_tick();
    chk(potk(0) == 32767, "R7 positive saturation", potk(0), 32767);
    chk(spk[0] == 1'b1, "R3 spike at maximum", int'(spk[0]), 1);
    do_tick();
    chk(potk(0) == 32767, "R7 no wrap at maximum", potk(0), 32767);

    // R7: negative saturation
    set_lane0(-2048, -255);
    for (int i = 0; i < 30; i++) do_tick();
    chk(potk(0) == -32768, "R7 negative saturation", potk(0), -32768);
    chk(spk[0] == 1'b0, "R3 no spike at minimum", int'(spk[0]), 0);
    do_tick();
    chk(potk(0) == -32768, "R7 no wrap at minimum", potk(0), -32768);

    // R1: reset clears after activity
    do_reset();
    chk(pot == '0 && spk == '0, "R1 reset after activity", potk(0), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule